// File: doc/BRIEF.md
# Two-Stage Gated Storage-Card Clock Divider

This block derives two clock enables for a storage-card interface from one parent clock enable, `src_en`. The first stage divides the parent enable by 1, 2, 4, 8 or 16 and produces the intermediate enable `hck_o`. The second stage divides that intermediate rate again by 2 or 4 and produces the final enable `ck_o`. The overall ratio from parent to final enable is the product of the two stages, from 2 up to 64. Each output has its own stop bit, so either enable can be silenced without disturbing the counters that feed it.

All settings live in one 16-bit configuration word, written through a simple write port and always readable on `rd_data`. The word is accepted only when it matches one of the ten legal settings. In every legal setting the final enable runs, and the intermediate enable is stopped whenever the pre-divider code is 2 or more. Two pulse inputs provide gating control:
- `dis_req` sets both stop bits.
- `ena_req` restores the stop pattern that belongs to the current pre-divider code.

A sequencer holds the divider codes in use. It adopts newly written codes only at the end of a full final-enable period, so no shortened period ever appears. The sequencer has two states:
- SEQ_STEADY: the codes in use equal the configured codes. It stays here while they match. When they differ on a period boundary, it loads the new codes at once and stays. When they differ with no boundary, it moves to SEQ_ARMED.
- SEQ_ARMED: a change is waiting. On the next period boundary it loads the configured codes and returns to SEQ_STEADY. If the configuration returns to the codes in use before then, it also returns to SEQ_STEADY.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `rd_data` reads 0x0300 (both stop bits set, both codes 0), `running` is 0, and `hck_o` and `ck_o` are 0.
- R2: The configuration word has this layout. Bit 9 stops `hck_o`, bit 8 stops `ck_o`, bits 4:2 hold the pre-divider code p, and bits 1:0 hold the final code q. All other bits read as zero. A write is accepted only if all of the following hold, and is then read back unchanged on `rd_data` from the next cycle:
  - p ≤ 4 and q ≤ 1;
  - bit 9 equals (p ≥ 2);
  - bit 8 is 0;
  - all other bits are 0.
- R3: A write that breaks any rule of R2 is ignored, and the configuration word keeps its previous value.
- R4: With bit 9 clear, `hck_o` pulses once every 2^p asserted `src_en` cycles. With bit 9 set, `hck_o` stays 0.
- R5: With bit 8 clear, `ck_o` pulses once every 2^p·2^(q+1) asserted `src_en` cycles, a ratio between 2 and 64. With bit 8 set, `ck_o` stays 0.
- R6: A `dis_req` pulse sets both stop bits in the next cycle, and both outputs then stay 0.
- R7: An `ena_req` pulse sets bit 9 to (p ≥ 2) and clears bit 8, leaving the codes unchanged.
- R8: `running` is 1 exactly when both stop bits are clear.
- R9: A code change takes effect only at the end of the final-enable period in progress. The period in progress keeps its old length, and the next period has the new length.
- R10: In one cycle, `dis_req` takes priority over `ena_req`, which takes priority over a write. A request that loses is ignored.
- R11: Each output pulse is a registered result of a cycle in which `src_en` was 1, and appears one cycle later. Cycles with `src_en` low do not advance either divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Parent clock enable |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Configuration write data |
| dis_req | input | 1 | Set both stop bits |
| ena_req | input | 1 | Restore the stop pattern of the current setting |
| rd_data | output | 16 | Current configuration word |
| running | output | 1 | Both stop bits clear |
| hck_o | output | 1 | Intermediate enable pulse |
| ck_o | output | 1 | Final enable pulse |

## Verification
The assertions assume that `src_en`, the write port and the two request pulses are synchronous to `clk` and stable around its rising edge. They also assume that nothing except the write port and the two requests changes the configuration. The stimulus drives every input on the falling edge and holds it for a whole cycle. It uses steady, sparse and pseudo-random patterns on `src_en`, and it deliberately issues colliding requests and illegal writes, which the design must resolve by priority or ignore.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int HSTOP_BIT = 9;
    localparam int CSTOP_BIT = 8;
    localparam int PRE_LSB   = 2;
    localparam int PRE_W     = 3;
    localparam int POST_LSB  = 0;
    localparam int POST_W    = 2;

    typedef struct packed {
        logic              hstop;
        logic              cstop;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } sd_cfg_t;

    typedef enum logic [0:0] {
        SEQ_STEADY = 1'b0,
        SEQ_ARMED  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg
    import sdclk_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int MAX_PRE    = 4,
    parameter int MAX_POST   = 1,
    parameter int HSTOP_FROM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dis_req,
    input  logic             ena_req,
    output sd_cfg_t          cfg,
    output logic [REG_W-1:0] rd_data
);
    localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((32'd1 << HSTOP_BIT) | (32'd1 << CSTOP_BIT)
                                              | (((32'd1 << PRE_W) - 32'd1) << PRE_LSB)
                                              | (((32'd1 << POST_W) - 32'd1) << POST_LSB));

    sd_cfg_t wr_cfg;
    sd_cfg_t cfg_nxt;
    logic    wr_legal;

    always_comb begin
        wr_cfg.hstop = wr_data[HSTOP_BIT];
        wr_cfg.cstop = wr_data[CSTOP_BIT];
        wr_cfg.pre   = wr_data[PRE_LSB +: PRE_W];
        wr_cfg.post  = wr_data[POST_LSB +: POST_W];
        wr_legal = ((wr_data & ~FIELD_MASK) == '0)
                && (int'(wr_cfg.pre) <= MAX_PRE)
                && (int'(wr_cfg.post) <= MAX_POST)
                && (wr_cfg.hstop == (int'(wr_cfg.pre) >= HSTOP_FROM))
                && !wr_cfg.cstop;
    end

    always_comb begin
        cfg_nxt = cfg;
        if (dis_req) begin
            cfg_nxt.hstop = 1'b1;
            cfg_nxt.cstop = 1'b1;
        end else if (ena_req) begin
            cfg_nxt.hstop = (int'(cfg.pre) >= HSTOP_FROM);
            cfg_nxt.cstop = 1'b0;
        end else if (wr_en && wr_legal) begin
            cfg_nxt = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '{hstop: 1'b1, cstop: 1'b1, pre: '0, post: '0};
        end else begin
            cfg <= cfg_nxt;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[HSTOP_BIT] = cfg.hstop;
        rd_data[CSTOP_BIT] = cfg.cstop;
        rd_data[PRE_LSB +: PRE_W] = cfg.pre;
        rd_data[POST_LSB +: POST_W] = cfg.post;
    end

    assert_reg_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg.pre) <= MAX_PRE) && (int'(cfg.post) <= MAX_POST));

    assert_illegal_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_legal && !dis_req && !ena_req) |=> $stable(cfg));

    assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (cfg.hstop && cfg.cstop));

    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_req && !dis_req) |=> (!cfg.cstop && $stable(cfg.pre) && $stable(cfg.post)));
endmodule

// File: rtl/sdclk_stage.sv
module sdclk_stage #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    assign last = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd,
    input  logic [PRE_W-1:0]  req_pre,
    input  logic [POST_W-1:0] req_post,
    output logic [PRE_W-1:0]  act_pre,
    output logic [POST_W-1:0] act_post
);
    seq_state_e st, st_nxt;
    logic       differ;
    logic       load;

    assign differ = (req_pre != act_pre) || (req_post != act_post);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SEQ_STEADY;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SEQ_STEADY: if (differ && !bnd) st_nxt = SEQ_ARMED;
            SEQ_ARMED:  if (bnd || !differ) st_nxt = SEQ_STEADY;
            default:    st_nxt = SEQ_STEADY;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (st)
            SEQ_STEADY: load = bnd && differ;
            SEQ_ARMED:  load = bnd;
            default:    load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre  <= '0;
            act_post <= '0;
        end else if (load) begin
            act_pre  <= req_pre;
            act_post <= req_post;
        end
    end

    assert_act_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> ($stable(act_pre) && $stable(act_post)));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int MAX_PRE    = 4,
    parameter int MAX_POST   = 1,
    parameter int HSTOP_FROM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dis_req,
    input  logic             ena_req,
    output logic [REG_W-1:0] rd_data,
    output logic             running,
    output logic             hck_o,
    output logic             ck_o
);
    localparam int PRE_CW  = (MAX_PRE < 1) ? 1 : MAX_PRE;
    localparam int POST_CW = MAX_POST + 1;

    sd_cfg_t             cfg;
    logic [PRE_W-1:0]    act_pre;
    logic [POST_W-1:0]   act_post;
    logic [PRE_CW-1:0]   pre_limit;
    logic [POST_CW-1:0]  post_limit;
    logic                pre_last;
    logic                post_last;
    logic                bnd;

    sdclk_cfg #(
        .REG_W(REG_W), .MAX_PRE(MAX_PRE), .MAX_POST(MAX_POST), .HSTOP_FROM(HSTOP_FROM)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dis_req(dis_req), .ena_req(ena_req), .cfg(cfg), .rd_data(rd_data)
    );

    assign pre_limit  = PRE_CW'((32'd1 << act_pre) - 32'd1);
    assign post_limit = POST_CW'((32'd2 << act_post) - 32'd1);

    sdclk_stage #(.CW(PRE_CW)) u_pre (
        .clk(clk), .rst_n(rst_n), .step(src_en), .limit(pre_limit), .last(pre_last)
    );

    sdclk_stage #(.CW(POST_CW)) u_post (
        .clk(clk), .rst_n(rst_n), .step(src_en && pre_last), .limit(post_limit), .last(post_last)
    );

    assign bnd = src_en && pre_last && post_last;

    sdclk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bnd(bnd), .req_pre(cfg.pre), .req_post(cfg.post),
        .act_pre(act_pre), .act_post(act_post)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hck_o <= 1'b0;
            ck_o  <= 1'b0;
        end else begin
            hck_o <= src_en && pre_last && !cfg.hstop;
            ck_o  <= bnd && !cfg.cstop;
        end
    end

    assign running = !cfg.hstop && !cfg.cstop;

    assert_hck_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hck_o |-> $past(src_en));

    assert_ck_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ck_o |-> $past(src_en && pre_last));

    assert_stop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg.hstop && cfg.cstop) |-> (!hck_o && !ck_o));
endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        dis_req = 1'b0;
    logic        ena_req = 1'b0;
    logic [15:0] rd_data;
    logic        running, hck_o, ck_o;

    always #10 clk = ~clk;

    sdclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_data(wr_data),
        .dis_req(dis_req), .ena_req(ena_req), .rd_data(rd_data), .running(running),
        .hck_o(hck_o), .ck_o(ck_o)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference
    int m_pre, m_post, a_pre, a_post, pc, qc;
    bit m_hs, m_cs, m_hck, m_ck;

    function automatic int enc(bit hs, bit cs, int pre, int post);
        return hs * 512 + cs * 256 + pre * 4 + post;
    endfunction

    function automatic bit legal(int v);
        int p, q;
        p = (v >> 2) & 7;
        q = v & 3;
        return ((v & ~32'h031F) == 0) && p <= 4 && q <= 1 && (((v >> 9) & 1) == (p >= 2 ? 1 : 0))
               && (((v >> 8) & 1) == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_post = 0; a_pre = 0; a_post = 0; pc = 0; qc = 0;
            m_hs = 1; m_cs = 1; m_hck = 0; m_ck = 0;
        end else begin
            int pd, qd, op, oq;
            bit pl, ql, bnd;
            pd = 1 << a_pre;
            qd = 2 << a_post;
            pl = (pc == pd - 1);
            ql = (qc == qd - 1);
            bnd = src_en && pl && ql;
            m_hck = src_en && pl && !m_hs;
            m_ck = bnd && !m_cs;
            if (src_en && pl) qc = ql ? 0 : qc + 1;
            if (src_en) pc = pl ? 0 : pc + 1;
            op = m_pre;
            oq = m_post;
            if (dis_req) begin
                m_hs = 1; m_cs = 1;
            end else if (ena_req) begin
                m_hs = (m_pre >= 2); m_cs = 0;
            end else if (wr_en && legal(int'(wr_data))) begin
                m_hs = wr_data[9]; m_cs = wr_data[8];
                m_pre = int'(wr_data[4:2]); m_post = int'(wr_data[1:0]);
            end
            if (bnd) begin
                a_pre = op; a_post = oq;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk(hck_o == m_hck, "R4 hck_o vs model", int'(hck_o), int'(m_hck));
            chk(ck_o == m_ck, "R5 ck_o vs model", int'(ck_o), int'(m_ck));
            chk(int'(rd_data) == enc(m_hs, m_cs, m_pre, m_post), "R2 rd_data vs model",
                int'(rd_data), enc(m_hs, m_cs, m_pre, m_post));
            chk(running == (!m_hs && !m_cs), "R8 running vs model", int'(running),
                int'(!m_hs && !m_cs));
        end
    endtask

    task automatic wr(int v);
        wr_en = 1'b1;
        wr_data = 16'(v);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic period(bit use_ck, output int n);
        n = -1;
        for (int k = 0; k < 300; k++) begin
            cyc();
            if (use_ck ? ck_o : hck_o) break;
        end
        for (int k = 1; k < 300; k++) begin
            cyc();
            if (use_ck ? ck_o : hck_o) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic count_ticks(int n, output int h, output int c);
        h = 0; c = 0;
        for (int k = 0; k < n; k++) begin
            cyc();
            h += int'(hck_o);
            c += int'(ck_o);
        end
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, h, c, lf;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0300, "R1 reset rd_data", int'(rd_data), 'h300);
        chk(!running, "R1 reset running", int'(running), 0);
        chk(!hck_o && !ck_o, "R1 reset outputs", int'(hck_o) + int'(ck_o), 0);
        rst_n = 1'b1;
        src_en = 1'b1;
        count_ticks(40, h, c);
        chk(h == 0 && c == 0, "R6 stopped after reset", h + c, 0);

        // R2 R4 R5: every legal setting
        for (int p = 0; p <= 4; p++) begin
            for (int q = 0; q <= 1; q++) begin
                wr(enc(p >= 2, 0, p, q));
                chk(int'(rd_data) == enc(p >= 2, 0, p, q), "R2 readback", int'(rd_data),
                    enc(p >= 2, 0, p, q));
                idle(140);
                period(1'b1, n);
                chk(n == (1 << p) * (2 << q), "R5 ck period", n, (1 << p) * (2 << q));
                if (p < 2) begin
                    period(1'b0, n);
                    chk(n == (1 << p), "R4 hck period", n, 1 << p);
                end else begin
                    count_ticks(40, h, c);
                    chk(h == 0, "R4 hck stopped", h, 0);
                end
            end
        end

        // R3 illegal writes ignored
        begin
            int keep;
            int bads[5];
            keep = enc(1, 0, 4, 1);
            bads = '{enc(1, 0, 5, 0), enc(0, 0, 1, 2), enc(1, 0, 1, 0), enc(0, 1, 0, 0),
                     enc(0, 0, 0, 0) | 'h1000};
            foreach (bads[i]) begin
                wr(bads[i]);
                chk(int'(rd_data) == keep, "R3 illegal ignored", int'(rd_data), keep);
            end
        end

        // R6 disable
        wr(enc(0, 0, 1, 0));
        idle(20);
        dis_req = 1'b1; cyc(); dis_req = 1'b0;
        chk(rd_data == 16'h0304, "R6 disable stops", int'(rd_data), 'h304);
        count_ticks(100, h, c);
        chk(h == 0 && c == 0, "R6 outputs silent", h + c, 0);
        chk(!running, "R8 not running when stopped", int'(running), 0);

        // R7 enable restores pattern
        ena_req = 1'b1; cyc(); ena_req = 1'b0;
        chk(rd_data == 16'h0004, "R7 enable pre<2", int'(rd_data), 'h004);
        chk(running, "R8 running when both clear", int'(running), 1);
        wr(enc(1, 0, 3, 1));
        dis_req = 1'b1; cyc(); dis_req = 1'b0;
        ena_req = 1'b1; cyc(); ena_req = 1'b0;
        chk(int'(rd_data) == enc(1, 0, 3, 1), "R7 enable pre>=2", int'(rd_data), enc(1, 0, 3, 1));
        chk(!running, "R8 hck stop keeps running low", int'(running), 0);

        // R9 change at period boundary
        wr(enc(1, 0, 4, 1));
        idle(200);
        period(1'b1, n);
        n = -1;
        for (int k = 1; k < 300; k++) begin
            if (k == 10) begin
                wr_en = 1'b1; wr_data = 16'(enc(0, 0, 0, 0));
            end else begin
                wr_en = 1'b0;
            end
            cyc();
            if (ck_o) begin
                n = k;
                break;
            end
        end
        wr_en = 1'b0;
        chk(n == 64, "R9 old period completes", n, 64);
        n = -1;
        for (int k = 1; k < 300; k++) begin
            cyc();
            if (ck_o) begin
                n = k;
                break;
            end
        end
        chk(n == 2, "R9 new period after boundary", n, 2);

        // R10 priority
        dis_req = 1'b1; ena_req = 1'b1; wr_en = 1'b1; wr_data = 16'(enc(0, 0, 1, 1));
        cyc();
        dis_req = 1'b0; ena_req = 1'b0; wr_en = 1'b0;
        chk(rd_data == 16'h0300, "R10 disable wins", int'(rd_data), 'h300);
        ena_req = 1'b1; wr_en = 1'b1; wr_data = 16'(enc(1, 0, 2, 0));
        cyc();
        ena_req = 1'b0; wr_en = 1'b0;
        chk(rd_data == 16'h0000, "R10 enable beats write", int'(rd_data), 0);

        // R11 sparse src_en: one in three
        idle(10);
        for (int k = 0; k < 60; k++) begin
            src_en = (k % 3 == 0);
            cyc();
        end
        n = -1;
        begin
            int last_t;
            int t;
            last_t = -1;
            t = 0;
            for (int k = 0; k < 200 && n < 0; k++) begin
                src_en = (k % 3 == 0);
                cyc();
                t++;
                if (ck_o) begin
                    if (last_t >= 0) n = t - last_t;
                    last_t = t;
                end
            end
        end
        chk(n == 6, "R11 sparse src_en ck period", n, 6);

        // R11 pseudo-random src_en with mixed settings
        lf = 'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = ((lf >> 1) ^ ((lf & 1) ? 'hB400 : 0)) & 'hFFFF;
            src_en = lf[0];
            if (k % 500 == 250) begin
                wr_en = 1'b1;
                wr_data = 16'(enc(((k / 500) % 5) >= 2, 0, (k / 500) % 5, (k / 500) % 2));
            end else begin
                wr_en = 1'b0;
            end
            dis_req = (k == 1700);
            ena_req = (k == 1900);
            cyc();
        end
        wr_en = 1'b0; dis_req = 1'b0; ena_req = 1'b0; src_en = 1'b0;
        count_ticks(20, h, c);
        chk(h == 0 && c == 0, "R11 no pulses without src_en", h + c, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule